// File: doc/BRIEF.md
# Timer Compare Match Unit

This block pairs a free-running 16-bit up-counter with a compare register. Whenever the count first becomes equal to the compare value, the unit carries out the action selected by a 4-bit mode code. It can drive an output latch to one, to zero or to the opposite level, it can raise only an interrupt flag, or it can raise a special event. A special event emits a trigger pulse in the same cycle as the match. It then clears the counter on the next timer tick, which makes the compare register the period of the counter. It can also latch a conversion-start request for an external converter.

Software reaches the unit through a single-cycle write port:

| Address | Register | Use |
|---|---|---|
| 0 | compare value | the value the count is matched against |
| 1 | control | the mode code, in bits [3:0] |
| 2 | timer | loads the counter |
| 3 | clear strobes | a 1 in bit 0 clears the interrupt flag; a 1 in bit 1 clears the overflow flag |

The timer advances on a one-cycle tick input that is synchronous to the system clock. The pad is modelled as a data output and a drive enable. The pad is not driven whenever the drive enable is low.

The unit has three small state machines:

- The output latch has the states LAT_LOW and LAT_HIGH. A match in set mode moves it to LAT_HIGH. A match in clear mode moves it to LAT_LOW. A match in toggle mode flips it. A control write of zero forces LAT_LOW.
- The special-event sequencer has the states SE_IDLE and SE_ARMED. SE_IDLE moves to SE_ARMED on a trigger that has no tick in the same cycle. SE_ARMED returns to SE_IDLE on a tick, on a timer load, or when the mode leaves special event.
- The converter request has the states ADC_IDLE and ADC_BUSY. ADC_IDLE moves to ADC_BUSY on a trigger while the converter is enabled. ADC_BUSY returns to ADC_IDLE when the done input is high and no new request arrives in that cycle.

Top module: `cmpunit_top`

## Requirements
- R1: A match event occurs in the first cycle in which the timer count equals the compare value. Its latch and flag effects appear one clock later. No further event occurs while the equality persists.
- R2: A match event under any of the mode codes 0010, 1000, 1001, 1010 and 1011 sets the interrupt flag. Every other code leaves the flag low. Once set, the flag stays set until a write to address 3 with bit 0 set.
- R3: Under mode 1010 a match sets only the interrupt flag. The latch is unchanged and the pad drive enable is low.
- R4: On a match, mode 1000 sets the latch, mode 1001 clears it and mode 0010 inverts it. Every other code leaves the latch unchanged.
- R5: Under mode 1011 the trigger output is high during the match-event cycle itself and low in all other cycles. The pad drive enable stays low in this mode.
- R6: Under mode 1011 the first tick at or after the trigger clears the timer to zero instead of incrementing it. With continuous ticks and a compare value K, the count therefore repeats 0..K.
- R7: If the compare value is rewritten between the trigger and the next tick so that the equality no longer holds, that tick increments the timer normally.
- R8: The overflow flag is set when a tick increments the count from 0xFFFF to 0. A special-event clear never sets it. A write to address 3 with bit 1 set clears it.
- R9: When the converter enable is high, a trigger sets the conversion request one clock later. The request stays high until the done input is seen high.
- R10: A write of zero to the control register forces the latch low.
- R11: The pad drive enable is high only when the tri-state enable is high and the mode is 0010, 1000 or 1001. The pad data output always shows the latch.
- R12: Reset leaves the count, the flags, the request, the trigger and the latch at zero. Each tick adds one to the count, and a write to address 2 loads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| tick | input | 1 | one-cycle timer advance |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register address |
| wr_data | input | 16 | register write data |
| adc_en | input | 1 | lets a special event request a conversion |
| adc_done | input | 1 | conversion finished, clears the request |
| tris_en | input | 1 | pad tri-state enable from the port logic |
| timer_cnt | output | 16 | timer count |
| ovf_flag | output | 1 | sticky overflow flag |
| irq_flag | output | 1 | sticky compare interrupt flag |
| trig_pulse | output | 1 | special event trigger |
| adc_go | output | 1 | latched conversion request |
| pin_out | output | 1 | pad data (compare latch) |
| pin_en | output | 1 | pad drive enable |

## Verification
A corrupted latch state machine becomes visible on pin_out one clock after the match that should have moved it, and that appears in every output mode of the sweep. If the special-event sequencer is stuck, or fails to honour a cancelled match, the count shows it on the very next tick as either 0 or K+1. A request state machine that drops the request early or holds it too long is seen on adc_go one cycle after the trigger or one cycle after the done pulse.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    localparam int ADDR_W = 2;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] REG_CMP  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] REG_TMR  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_CLR  = 2'd3;

    localparam logic [MODE_W-1:0] CODE_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_SET    = 4'b1000;
    localparam logic [MODE_W-1:0] CODE_CLR    = 4'b1001;
    localparam logic [MODE_W-1:0] CODE_IRQ    = 4'b1010;
    localparam logic [MODE_W-1:0] CODE_SEV    = 4'b1011;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_SET,
        ACT_CLR,
        ACT_IRQ,
        ACT_SEV
    } act_e;

    typedef enum logic { LAT_LOW, LAT_HIGH } lat_state_e;
    typedef enum logic { SE_IDLE, SE_ARMED } se_state_e;
    typedef enum logic { ADC_IDLE, ADC_BUSY } adc_state_e;

    function automatic act_e decode_mode(input logic [MODE_W-1:0] code);
        act_e a;
        case (code)
            CODE_TOGGLE: a = ACT_TOGGLE;
            CODE_SET:    a = ACT_SET;
            CODE_CLR:    a = ACT_CLR;
            CODE_IRQ:    a = ACT_IRQ;
            CODE_SEV:    a = ACT_SEV;
            default:     a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cmpu_regs.sv
module cmpu_regs
    import cmpu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TW-1:0]     wr_data,
    output logic [TW-1:0]     cmp_val,
    output logic [MODE_W-1:0] mode,
    output logic              ctrl_zero,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_load_val,
    output logic              clr_irq,
    output logic              clr_ovf
);

    logic sel_cmp, sel_ctrl, sel_tmr, sel_clr;

    always_comb begin
        sel_cmp  = wr_en && (wr_addr == REG_CMP);
        sel_ctrl = wr_en && (wr_addr == REG_CTRL);
        sel_tmr  = wr_en && (wr_addr == REG_TMR);
        sel_clr  = wr_en && (wr_addr == REG_CLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '0;
            mode    <= '0;
        end else begin
            if (sel_cmp)  cmp_val <= wr_data;
            if (sel_ctrl) mode    <= wr_data[MODE_W-1:0];
        end
    end

    always_comb begin
        ctrl_zero    = sel_ctrl && (wr_data[MODE_W-1:0] == '0);
        tmr_load     = sel_tmr;
        tmr_load_val = wr_data;
        clr_irq      = sel_clr && wr_data[0];
        clr_ovf      = sel_clr && wr_data[1];
    end

endmodule

// File: rtl/cmpu_timer.sv
module cmpu_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          sev_reset,
    input  logic          clr_ovf,
    output logic [TW-1:0] count,
    output logic          ovf
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    logic wrap;

    always_comb wrap = tick && !load && !sev_reset && (count == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            if (sev_reset) count <= '0;
            else           count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (clr_ovf) ovf <= 1'b0;
    end

endmodule

// File: rtl/cmpu_match.sv
module cmpu_match #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] count,
    input  logic [TW-1:0] cmp_val,
    output logic          match_now,
    output logic          match_evt
);

    logic match_seen;

    always_comb begin
        match_now = (count == cmp_val);
        match_evt = match_now && !match_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_seen <= 1'b0;
        else        match_seen <= match_now;
    end

endmodule

// File: rtl/cmpu_action.sv
module cmpu_action
    import cmpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act,
    input  logic match_evt,
    input  logic ctrl_zero,
    input  logic clr_irq,
    input  logic tris_en,
    output logic irq,
    output logic pin_out,
    output logic pin_en
);

    lat_state_e lat_q, lat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= LAT_LOW;
        else        lat_q <= lat_d;
    end

    always_comb begin
        lat_d = lat_q;
        if (ctrl_zero) begin
            lat_d = LAT_LOW;
        end else if (match_evt) begin
            unique case (lat_q)
                LAT_LOW: begin
                    if (act == ACT_SET || act == ACT_TOGGLE) lat_d = LAT_HIGH;
                end
                LAT_HIGH: begin
                    if (act == ACT_CLR || act == ACT_TOGGLE) lat_d = LAT_LOW;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             irq <= 1'b0;
        else if (match_evt && act != ACT_NONE)  irq <= 1'b1;
        else if (clr_irq)                       irq <= 1'b0;
    end

    always_comb begin
        pin_out = (lat_q == LAT_HIGH);
        pin_en  = tris_en &&
                  (act == ACT_SET || act == ACT_CLR || act == ACT_TOGGLE);
    end

endmodule

// File: rtl/cmpu_sevent.sv
module cmpu_sevent
    import cmpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sev_mode,
    input  logic match_evt,
    input  logic match_now,
    input  logic tick,
    input  logic tmr_load,
    input  logic adc_en,
    input  logic adc_done,
    output logic trig,
    output logic sev_reset,
    output logic adc_go
);

    se_state_e  se_q, se_d;
    adc_state_e ad_q, ad_d;
    logic       req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se_q <= SE_IDLE;
            ad_q <= ADC_IDLE;
        end else begin
            se_q <= se_d;
            ad_q <= ad_d;
        end
    end

    always_comb begin
        se_d = se_q;
        unique case (se_q)
            SE_IDLE: begin
                if (trig && !tick && !tmr_load) se_d = SE_ARMED;
            end
            SE_ARMED: begin
                if (tick || tmr_load || !sev_mode) se_d = SE_IDLE;
            end
        endcase
    end

    always_comb begin
        ad_d = ad_q;
        unique case (ad_q)
            ADC_IDLE: begin
                if (req) ad_d = ADC_BUSY;
            end
            ADC_BUSY: begin
                if (adc_done && !req) ad_d = ADC_IDLE;
            end
        endcase
    end

    always_comb begin
        trig      = sev_mode && match_evt;
        req       = trig && adc_en;
        sev_reset = tick && sev_mode && match_now && !tmr_load &&
                    (se_q == SE_ARMED || trig);
        adc_go    = (ad_q == ADC_BUSY);
    end

endmodule

// File: rtl/cmpunit_top.sv
module cmpunit_top
    import cmpu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic              adc_en,
    input  logic              adc_done,
    input  logic              tris_en,
    output logic [TW-1:0]     timer_cnt,
    output logic              ovf_flag,
    output logic              irq_flag,
    output logic              trig_pulse,
    output logic              adc_go,
    output logic              pin_out,
    output logic              pin_en
);

    logic [TW-1:0]     cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              ctrl_zero, tmr_load, clr_irq, clr_ovf;
    logic [TW-1:0]     tmr_load_val;
    logic              match_now, match_evt, sev_reset;
    act_e              act;

    always_comb act = decode_mode(mode_q);

    cmpu_regs #(.TW(TW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cmp_val      (cmp_q),
        .mode         (mode_q),
        .ctrl_zero    (ctrl_zero),
        .tmr_load     (tmr_load),
        .tmr_load_val (tmr_load_val),
        .clr_irq      (clr_irq),
        .clr_ovf      (clr_ovf)
    );

    cmpu_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (tmr_load),
        .load_val  (tmr_load_val),
        .sev_reset (sev_reset),
        .clr_ovf   (clr_ovf),
        .count     (timer_cnt),
        .ovf       (ovf_flag)
    );

    cmpu_match #(.TW(TW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (timer_cnt),
        .cmp_val   (cmp_q),
        .match_now (match_now),
        .match_evt (match_evt)
    );

    cmpu_action u_action (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .match_evt (match_evt),
        .ctrl_zero (ctrl_zero),
        .clr_irq   (clr_irq),
        .tris_en   (tris_en),
        .irq       (irq_flag),
        .pin_out   (pin_out),
        .pin_en    (pin_en)
    );

    cmpu_sevent u_sevent (
        .clk       (clk),
        .rst_n     (rst_n),
        .sev_mode  (act == ACT_SEV),
        .match_evt (match_evt),
        .match_now (match_now),
        .tick      (tick),
        .tmr_load  (tmr_load),
        .adc_en    (adc_en),
        .adc_done  (adc_done),
        .trig      (trig_pulse),
        .sev_reset (sev_reset),
        .adc_go    (adc_go)
    );

endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [TW-1:0] wr_data,
    input logic          adc_done,
    input logic [TW-1:0] timer_cnt,
    input logic [TW-1:0] cmp_q,
    input logic [3:0]    mode_q,
    input logic          ovf_flag,
    input logic          irq_flag,
    input logic          trig_pulse,
    input logic          adc_go
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    assert_trig_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (timer_cnt == cmp_q && mode_q == 4'b1011));

    assert_irq_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(wr_en && wr_addr == 2'd3 && wr_data[0]));

    assert_ovf_only_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(tick) && $past(timer_cnt) == CNT_MAX));

    assert_sev_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && trig_pulse && !(wr_en && wr_addr == 2'd2)) |=> (timer_cnt == '0));

    assert_go_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_go && !adc_done) |=> adc_go);

    assert_tick_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && wr_addr == 2'd2) && timer_cnt != cmp_q)
        |=> (timer_cnt == $past(timer_cnt) + 1'b1));

endmodule

bind cmpunit_top cmpu_checker #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .adc_done   (adc_done),
    .timer_cnt  (timer_cnt),
    .cmp_q      (cmp_q),
    .mode_q     (mode_q),
    .ovf_flag   (ovf_flag),
    .irq_flag   (irq_flag),
    .trig_pulse (trig_pulse),
    .adc_go     (adc_go)
);

// File: tb/cmpunit_top_test.sv
`timescale 1ns/1ps
module cmpunit_top_test;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic          adc_en = 1'b0;
    logic          adc_done = 1'b0;
    logic          tris_en = 1'b1;
    logic [TW-1:0] timer_cnt;
    logic          ovf_flag, irq_flag, trig_pulse, adc_go, pin_out, pin_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cmpunit_top #(.TW(TW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .adc_en     (adc_en),
        .adc_done   (adc_done),
        .tris_en    (tris_en),
        .timer_cnt  (timer_cnt),
        .ovf_flag   (ovf_flag),
        .irq_flag   (irq_flag),
        .trig_pulse (trig_pulse),
        .adc_go     (adc_go),
        .pin_out    (pin_out),
        .pin_en     (pin_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    task automatic prep(input logic [TW-1:0] k, input logic [3:0] m);
        wr(2'd1, 16'h0001);
        wr(2'd0, k);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0003);
        wr(2'd1, {12'h000, m});
    endtask

    function automatic bit is_active(input logic [3:0] m);
        return (m == 4'b0010 || m == 4'b1000 || m == 4'b1001 ||
                m == 4'b1010 || m == 4'b1011);
    endfunction

    function automatic bit is_drive(input logic [3:0] m);
        return (m == 4'b0010 || m == 4'b1000 || m == 4'b1001);
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic exp_lat;
        exp_lat = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 reset timer", timer_cnt, 0);
        chk("R12 reset irq", irq_flag, 0);
        chk("R12 reset ovf", ovf_flag, 0);
        chk("R12 reset go", adc_go, 0);
        chk("R12 reset trig", trig_pulse, 0);
        chk("R12 reset latch", pin_out, 0);
        chk("R11 reset pin_en", pin_en, 0);

        // Sweep of all mode codes, two compare values each: R1 R2 R3 R4 R5 R6 R9 R11
        for (int mi = 0; mi < 16; mi++) begin
            for (int ki = 0; ki < 2; ki++) begin
                logic [3:0]    m;
                logic [TW-1:0] k;
                bit            sev;
                m   = mi[3:0];
                k   = (ki == 0) ? 16'd2 : 16'd5;
                sev = (m == 4'b1011);
                adc_en = (ki == 1);
                prep(k, m);
                if (m == 4'b0000) exp_lat = 1'b0;
                for (int t = 1; t < k; t++) do_tick();
                chk("R5 no trig before match", trig_pulse, 0);
                do_tick();
                chk("R5 trig in match cycle", trig_pulse, sev);
                chk("R1 no flag before next edge", irq_flag, 0);
                @(negedge clk);
                chk("R5 trig single cycle", trig_pulse, 0);
                if (m == 4'b1000) exp_lat = 1'b1;
                else if (m == 4'b1001) exp_lat = 1'b0;
                else if (m == 4'b0010) exp_lat = ~exp_lat;
                chk("R2 irq per mode", irq_flag, is_active(m));
                chk("R4 R3 latch action", pin_out, exp_lat);
                chk("R11 drive enable per mode", pin_en, is_drive(m));
                chk("R9 request", adc_go, sev && (ki == 1));
                chk("R1 timer at match", timer_cnt, k);
                do_tick();
                chk("R6 timer after next tick", timer_cnt, sev ? 0 : k + 1);
                chk("R2 irq sticky", irq_flag, is_active(m));
                chk("R4 no second action", pin_out, exp_lat);
                if (sev && ki == 1) begin
                    chk("R9 request held", adc_go, 1);
                    pulse_done();
                    chk("R9 request cleared by done", adc_go, 0);
                end
                chk("R8 no overflow", ovf_flag, 0);
            end
        end
        adc_en = 1'b0;

        // R2 write-1-to-clear
        wr(2'd3, 16'h0001);
        chk("R2 irq cleared", irq_flag, 0);

        // R6 continuous ticks, period K+1 with K=3
        prep(16'd3, 4'b1011);
        @(negedge clk);
        tick = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            chk("R6 period count", timer_cnt, i % 4);
            chk("R5 trig at each match", trig_pulse, (i % 4) == 3);
        end
        tick = 1'b0;
        chk("R8 sev clear sets no overflow", ovf_flag, 0);

        // R7 cancel by compare rewrite, with request R9
        adc_en = 1'b1;
        prep(16'd4, 4'b1011);
        for (int t = 0; t < 4; t++) do_tick();
        chk("R7 trig fired", trig_pulse, 1);
        wr(2'd0, 16'd9);
        chk("R9 request set", adc_go, 1);
        do_tick();
        chk("R7 reset cancelled", timer_cnt, 5);
        for (int t = 0; t < 4; t++) do_tick();
        chk("R7 new match at 9", trig_pulse, 1);
        do_tick();
        chk("R6 reset at new value", timer_cnt, 0);
        pulse_done();
        chk("R9 cleared", adc_go, 0);
        adc_en = 1'b0;

        // R8 overflow
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'd100);
        wr(2'd2, 16'hFFFE);
        chk("R12 timer load", timer_cnt, 16'hFFFE);
        do_tick();
        chk("R8 no ovf at FFFF", ovf_flag, 0);
        do_tick();
        chk("R8 wrap to zero", timer_cnt, 0);
        chk("R8 ovf set", ovf_flag, 1);
        wr(2'd3, 16'h0002);
        chk("R8 ovf cleared", ovf_flag, 0);

        // R10 control write of zero
        prep(16'd2, 4'b1000);
        do_tick();
        do_tick();
        @(negedge clk);
        chk("R10 latch high first", pin_out, 1);
        wr(2'd1, 16'h0000);
        chk("R10 latch forced low", pin_out, 0);
        chk("R11 no drive mode zero", pin_en, 0);
        wr(2'd1, 16'h0008);
        chk("R10 latch still low", pin_out, 0);
        chk("R11 drive in set mode", pin_en, 1);

        // R11 tri-state enable low
        tris_en = 1'b0;
        @(negedge clk);
        chk("R11 no drive without enable", pin_en, 0);
        tris_en = 1'b1;

        finish_run();
    end

endmodule